// File: doc/BRIEF.md
# Switch-Input Polling Sequencer

This block times the periodic scan of a bank of external switch contacts. A prescaler divides the system clock into a fixed timebase tick, and all timing is counted in ticks. At the start of every poll period the block turns on the wetting-current enables so that external capacitors on the contact lines can charge. The comparator sample window lies in the last part of that active time, while the current is still flowing. During the window the block steps a sample index through the inputs, from input 0 to the last input, and gives each input a fixed number of ticks.

Each input's comparator bit is taken once, on the last clock of its own window. No filtering is applied, so a level that is present only outside an input's window is not seen until a later poll. The captured bits are collected in a shadow register. They are copied into the status register together, on the same clock edge on which the current enables drop. If the new status differs from the old one, a one-clock interrupt pulse is raised. The period and active-time settings are read in at the start of each poll. The active time is raised so that the whole sample window always fits inside it, and the period is raised so that at least one idle tick always follows the active time.

Top module: `sps_top`

## Requirements
- R1: The tick is one clock in every TICK_DIV clocks. Poll periods follow one another without a gap, each lasting the effective period in ticks. The first poll begins on the first clock edge after reset is released.
- R2: All bits of `wet_en_o` are equal. They are high for exactly the first A ticks of each poll, where A is the effective active time.
- R3: The effective active time is max(`active_i`, N_IN*WIN_TICKS). The effective period is max(`period_i`, A+1).
- R4: `sample_o` is high exactly during the final N_IN*WIN_TICKS ticks of the active time, and never while the enables are low.
- R5: While `sample_o` is high, `sample_idx_o` equals the number of whole WIN_TICKS-tick slots elapsed since the window opened. It therefore runs from 0 up to N_IN-1 and starts again at 0 in every poll.
- R6: Bit i of the new status is the value of `cmp_i[i]` on the clock edge that ends the last tick of input i's slot. Values of `cmp_i[i]` at any other time have no effect on the status.
- R7: `status_o` changes only on the clock edge on which `wet_en_o` falls, and all bits change together on that edge.
- R8: `irq_o` is high for exactly one clock, the clock after that edge, and only when the new status differs from the previous one.
- R9: While `rst_ni` is low, `wet_en_o`, `sample_o`, `status_o` and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | PER_W | Poll period in ticks |
| active_i | input | ACT_W | Wetting active time in ticks |
| cmp_i | input | N_IN | Comparator result, one bit per input |
| wet_en_o | output | N_IN | Wetting current enables |
| sample_o | output | 1 | Comparator sample window strobe |
| sample_idx_o | output | IDX_W | Index of the input being sampled |
| status_o | output | N_IN | Latched switch status |
| irq_o | output | 1 | Status-change pulse |

## Verification
The bench builds the block with four inputs, a two-tick slot per input and a three-clock tick. This makes a poll only a few dozen clocks long, so every clock of several whole polls can be predicted arithmetically and compared. Four period and active-time pairs are used. Together they reach a normal setting, an active time clamped up to the eight-tick window, a period clamped up to the active time plus one, and an active time exactly equal to the window. Each comparator line is driven to the inverse of its intended value everywhere outside its own slot, and repeated patterns exercise both the pulse and the no-pulse case of the interrupt.

// File: rtl/sps_pkg.sv
package sps_pkg;
  function automatic int sps_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sps_prescaler.sv
module sps_prescaler #(
  parameter int TICK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sps_timer.sv
module sps_timer import sps_pkg::*; #(
  parameter int N_IN      = 24,
  parameter int WIN_TICKS = 18,
  parameter int PER_W     = 17,
  parameter int ACT_W     = 10,
  localparam int CNT_W    = sps_max(PER_W, ACT_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [ACT_W-1:0] active_i,
  output logic             load_o,
  output logic             en_o,
  output logic             sample_o,
  output logic             commit_o
);
  localparam int SPAN = N_IN * WIN_TICKS;
  localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(SPAN);

  logic             loaded_q;
  logic [CNT_W-1:0] pcnt_q, act_q, per_q;
  logic [CNT_W-1:0] act_in, per_in, act_eff, per_eff, win_start;

  // clamp so the full sample window fits, with one idle tick after it
  assign act_in  = CNT_W'(active_i);
  assign per_in  = CNT_W'(period_i);
  assign act_eff = (act_in < SPAN_C) ? SPAN_C : act_in;
  assign per_eff = (per_in > act_eff) ? per_in : act_eff + 1'b1;

  assign load_o    = !loaded_q || (tick_i && pcnt_q == per_q - 1'b1);
  assign en_o      = pcnt_q < act_q;
  assign win_start = act_q - SPAN_C;
  assign sample_o  = en_o && (pcnt_q >= win_start);
  assign commit_o  = tick_i && loaded_q && (pcnt_q == act_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      pcnt_q   <= '0;
      act_q    <= '0;
      per_q    <= '0;
    end else begin
      loaded_q <= 1'b1;
      if (load_o) begin
        pcnt_q <= '0;
        act_q  <= act_eff;
        per_q  <= per_eff;
      end else if (tick_i) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  // R4
  sample_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> en_o);

  // R3
  act_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> (act_q >= SPAN_C && per_q > act_q));
endmodule

// File: rtl/sps_capture.sv
module sps_capture #(
  parameter int N_IN      = 24,
  parameter int WIN_TICKS = 18,
  localparam int IDX_W    = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int WW       = $clog2(WIN_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             sample_i,
  input  logic             commit_i,
  input  logic [N_IN-1:0]  cmp_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_IN-1:0]  status_o,
  output logic             irq_o
);
  logic [WW-1:0]    win_q;
  logic [IDX_W-1:0] idx_q;
  logic [N_IN-1:0]  shadow_q, shadow_nxt, status_q;
  logic             irq_q, slot_end;

  assign slot_end = tick_i && sample_i && (win_q == WW'(WIN_TICKS - 1));

  always_comb begin
    shadow_nxt = shadow_q;
    if (slot_end) shadow_nxt[idx_q] = cmp_i[idx_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      idx_q    <= '0;
      shadow_q <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (load_i) begin
        win_q <= '0;
        idx_q <= '0;
      end else if (tick_i && sample_i) begin
        if (slot_end) begin
          win_q <= '0;
          if (idx_q != IDX_W'(N_IN - 1)) idx_q <= idx_q + 1'b1;
        end else begin
          win_q <= win_q + 1'b1;
        end
      end
      shadow_q <= shadow_nxt;
      if (commit_i) begin
        status_q <= shadow_nxt;
        irq_q    <= (shadow_nxt != status_q);
      end else begin
        irq_q <= 1'b0;
      end
    end
  end

  assign idx_o    = idx_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/sps_top.sv
module sps_top import sps_pkg::*; #(
  parameter int N_IN      = 24,
  parameter int TICK_DIV  = 50,
  parameter int WIN_TICKS = 18,
  parameter int PER_W     = 17,
  parameter int ACT_W     = 10,
  localparam int IDX_W    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic [ACT_W-1:0] active_i,
  input  logic [N_IN-1:0]  cmp_i,
  output logic [N_IN-1:0]  wet_en_o,
  output logic             sample_o,
  output logic [IDX_W-1:0] sample_idx_o,
  output logic [N_IN-1:0]  status_o,
  output logic             irq_o
);
  logic tick, load, en, commit;

  sps_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  sps_timer #(
    .N_IN(N_IN), .WIN_TICKS(WIN_TICKS), .PER_W(PER_W), .ACT_W(ACT_W)
  ) u_timer (
    .clk_i, .rst_ni, .tick_i(tick), .period_i, .active_i,
    .load_o(load), .en_o(en), .sample_o, .commit_o(commit)
  );

  sps_capture #(.N_IN(N_IN), .WIN_TICKS(WIN_TICKS)) u_cap (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .sample_i(sample_o),
    .commit_i(commit), .cmp_i, .idx_o(sample_idx_o), .status_o, .irq_o
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_wet
    assign wet_en_o[g] = en;
  end

  // R7
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wet_en_o[0] && $past(wet_en_o[0])) |-> $stable(status_o));

  // R8
  irq_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($fell(wet_en_o[0]) && status_o != $past(status_o)));

  // R5
  idx_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $past(sample_o)) |-> sample_idx_o >= $past(sample_idx_o));

  // R2
  en_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wet_en_o) == 0 || $countones(wet_en_o) == N_IN);
endmodule

// File: tb/sps_top_tb.sv
module sps_top_tb;
  localparam int N    = 4;
  localparam int DIV  = 3;
  localparam int WIN  = 2;
  localparam int PW   = 6;
  localparam int AW   = 5;
  localparam int SPAN = N * WIN;
  localparam int IW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period = '0;
  logic [AW-1:0] active = '0;
  logic [N-1:0]  cmp = '0;
  logic [N-1:0]  wet_en, status;
  logic          sample, irq;
  logic [IW-1:0] idx;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  sps_top #(.N_IN(N), .TICK_DIV(DIV), .WIN_TICKS(WIN), .PER_W(PW), .ACT_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .active_i(active),
    .cmp_i(cmp), .wet_en_o(wet_en), .sample_o(sample), .sample_idx_o(idx),
    .status_o(status), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat(input int n, input int r);
    case (n)
      0, 1:    return 5 ^ r;
      2, 3:    return 10 ^ r;
      default: return 15 ^ r;
    endcase
  endfunction

  task automatic run(input int p, input int a, input int r);
    int ae, pe, ws;
    ae = (a < SPAN) ? SPAN : a;           // R3
    pe = (p > ae) ? p : ae + 1;
    ws = ae - SPAN;
    period = PW'(p);
    active = AW'(a);
    cmp    = '0;
    rst_n  = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 en", int'(wet_en), 0);
    check("R9 sample", int'(sample), 0);
    check("R9 status", int'(status), 0);
    check("R9 irq", int'(irq), 0);
    rst_n = 1'b1;
    for (int e = 1; e <= 5 * pe * DIV; e++) begin
      int t, pc, n, exp_st, exp_irq, exp_en, exp_smp;
      @(posedge clk);
      @(negedge clk);
      t  = e / DIV;                        // R1
      pc = t % pe;
      n  = t / pe;
      exp_en  = (pc < ae) ? 1 : 0;
      exp_smp = (pc >= ws && pc < ae) ? 1 : 0;
      if (pc >= ae)    exp_st = pat(n, r);
      else if (n == 0) exp_st = 0;
      else             exp_st = pat(n - 1, r);
      exp_irq = 0;
      if (e % DIV == 0 && pc == ae)
        exp_irq = (pat(n, r) != ((n == 0) ? 0 : pat(n - 1, r))) ? 1 : 0;
      check("R1 R2 en", int'(wet_en), exp_en ? (1 << N) - 1 : 0);
      check("R4 sample", int'(sample), exp_smp);
      if (exp_smp) check("R5 idx", int'(idx), (pc - ws) / WIN);
      check("R6 R7 status", int'(status), exp_st);
      check("R8 irq", int'(irq), exp_irq);
      // R6: each line holds its pattern only inside its own slot, inverted elsewhere
      for (int i = 0; i < N; i++) begin
        logic b;
        b = logic'((pat(n, r) >> i) & 1);
        cmp[i] = (pc >= ws + i * WIN && pc < ws + (i + 1) * WIN) ? b : ~b;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    run(20, 12, 0);  // normal setting
    run(12, 3, 1);   // R3 active clamped up to window
    run(5, 9, 2);    // R3 period clamped to active+1
    run(9, 8, 3);    // active equals window
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule